// File: doc/BRIEF.md
# Serial EEPROM Slave Command and Page-Write Engine

This block is a synthesizable model of the command side of a byte-wide serial EEPROM that answers as an SPI slave in mode 0. It oversamples the serial clock, the select and the serial data input with the system clock. It decodes single-byte commands that arm the write-enable latch, write the status register, read the status register, read the array and write the array. An array write carries a 24-bit address. The data bytes that follow are gathered into a one-page buffer whose in-page pointer wraps inside the page.

When the select is released exactly on a byte boundary after at least one data byte, the write is committed. A self-timed write cycle then starts, and it lasts a parameterised number of system-clock cycles. During this cycle the buffered bytes are copied into an on-chip array. The busy flag reads as set, array reads and new write commands are refused, and the write-enable latch clears itself when the cycle ends. The serial output is only driven while a status or array read is streaming. At all other times its enable is low and the pad is meant to float.

Top module: `spi_ee_slave`

## Requirements
- R1: After reset the output enable is low, and a status read returns 0x00.
- R2: Command 0x06 sets the write-enable latch only when the select rises right after its eighth bit. A frame that carries any further bit after those eight (including a write command in the same frame) leaves the latch clear.
- R3: Command 0x05 streams the status byte MSB first, with data changing on falling serial clock. Bit 0 is busy, bit 1 is the write-enable latch, bits 2 and 3 are the two protect bits, bit 7 is the protect-enable bit, and bits 6..4 read 0.
- R4: A write command 0x02 issued while the write-enable latch is clear changes neither the array nor the status.
- R5: Write command 0x02 takes a 24-bit address, MSB first, and only its low ADDR_W bits select the byte. Successive data bytes land at successive addresses, and read command 0x03 with the same address returns them.
- R6: Data that runs past the end of a 2^PAGE_W-byte page wraps to the first byte of the same page, and later bytes overwrite earlier ones.
- R7: If the select rises at any bit position other than right after a full data byte, the write is abandoned. The array is unchanged, no write cycle starts, and the latch stays set.
- R8: A committed write sets the busy bit, and busy stays set for WR_CYCLES system clocks.
- R9: The write-enable latch clears by itself when the write cycle ends.
- R10: Array read command 0x03 received during the write cycle is refused, and the output enable stays low for the whole frame.
- R11: While busy, commands 0x06, 0x02 and 0x01 are ignored.
- R12: Command 0x01 followed by one byte, with the latch set and the frame closed on the byte boundary, stores bits 7, 3 and 2 of that byte as protect-enable, protect bit 1 and protect bit 0. It also starts a write cycle.
- R13: The output enable is low whenever the select is high.
- R14: Bytes of the page that the write frame did not load keep their previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial pins and times the write cycle |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from the master |
| sel_n | input | 1 | Active-low chip select |
| ser_in | input | 1 | Serial data from master, sampled on rising serial clock |
| ser_out | output | 1 | Serial data to master, updated on falling serial clock |
| ser_out_en | output | 1 | High while ser_out must be driven; low means high impedance |

## Verification
The assertions assume that the serial pins change slowly against the system clock. Each serial-clock phase must span several system clocks, so that a synchronised rising edge and the following falling edge never land in the same cycle and the select never moves within a phase that carries a bit. They also assume that WR_CYCLES is at least the page size, so the copy of the buffer finishes inside the busy window. The bench drives every serial-clock phase for six system clocks and toggles the select only with the serial clock low and idle on both sides. It samples the returned data just before each rising serial edge, so every edge meets these conditions.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

    localparam logic [7:0] OP_ARM    = 8'h06;
    localparam logic [7:0] OP_STATRD = 8'h05;
    localparam logic [7:0] OP_STATWR = 8'h01;
    localparam logic [7:0] OP_PROG   = 8'h02;
    localparam logic [7:0] OP_FETCH  = 8'h03;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_OPC,
        PH_ARMED,
        PH_ADDR,
        PH_WDATA,
        PH_SRDATA,
        PH_RSTAT,
        PH_RDATA,
        PH_IGNORE
    } ee_phase_t;

    typedef struct packed {
        logic sck_rise;
        logic sck_fall;
        logic sel_start;
        logic sel_end;
        logic selected;
        logic mosi;
    } spi_ev_t;

    typedef struct packed {
        logic       wpen;
        logic [1:0] bp;
        logic       wel;
    } ee_stat_t;

    function automatic logic [7:0] stat_byte(input ee_stat_t s, input logic busy);
        return {s.wpen, 3'b000, s.bp, s.wel, busy};
    endfunction

endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync
    import spi_ee_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sck_in,
    input  logic    sel_n_in,
    input  logic    din_in,
    output spi_ev_t ev
);
    logic [SYNC_STAGES:0]   sck_p;
    logic [SYNC_STAGES:0]   sel_p;
    logic [SYNC_STAGES-1:0] din_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p <= '0;
            sel_p <= '1;
            din_p <= '0;
        end else begin
            sck_p <= {sck_p[SYNC_STAGES-1:0], sck_in};
            sel_p <= {sel_p[SYNC_STAGES-1:0], sel_n_in};
            din_p <= {din_p[SYNC_STAGES-2:0], din_in};
        end
    end

    always_comb begin
        ev.sck_rise  = sck_p[SYNC_STAGES-1] & ~sck_p[SYNC_STAGES];
        ev.sck_fall  = ~sck_p[SYNC_STAGES-1] & sck_p[SYNC_STAGES];
        ev.sel_start = ~sel_p[SYNC_STAGES-1] & sel_p[SYNC_STAGES];
        ev.sel_end   = sel_p[SYNC_STAGES-1] & ~sel_p[SYNC_STAGES];
        ev.selected  = ~sel_p[SYNC_STAGES-1];
        ev.mosi      = din_p[SYNC_STAGES-1];
    end

endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array
    import spi_ee_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int PAGE_W    = 8,
    parameter int WR_CYCLES = 300,
    localparam int PAGE     = 1 << PAGE_W,
    localparam int PIDX_W   = ADDR_W - PAGE_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [PIDX_W-1:0]          start_page,
    input  logic [PAGE-1:0][7:0]       pbuf,
    input  logic [PAGE-1:0]            pmask,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [7:0]                 rd_data,
    output logic                       wip
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CW    = $clog2(WR_CYCLES + 1);

    logic [7:0]        mem [DEPTH];
    logic [CW-1:0]     cnt;
    logic [PIDX_W-1:0] page_q;
    logic [PAGE_W-1:0] slot;
    logic              in_copy;

    assign slot    = cnt[PAGE_W-1:0];
    assign in_copy = wip && (int'(cnt) < PAGE);

    always_ff @(posedge clk) begin
        if (rst) begin
            wip    <= 1'b0;
            cnt    <= '0;
            page_q <= '0;
        end else if (start && !wip) begin
            wip    <= 1'b1;
            cnt    <= '0;
            page_q <= start_page;
        end else if (wip) begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(WR_CYCLES - 1)) wip <= 1'b0;
        end
    end

    // one buffer slot per cycle while busy; unmarked slots keep the array byte
    always_ff @(posedge clk) begin
        if (in_copy && pmask[slot]) mem[{page_q, slot}] <= pbuf[slot];
    end

    assign rd_data = mem[rd_addr];

    a_r11_no_restart_busy: assert property (@(posedge clk) disable iff (rst)
        wip |-> !start);
    a_r8_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        start |=> wip);
    a_r8_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
        $rose(wip) |-> $past(start));

endmodule

// File: rtl/spi_ee_cmd.sv
module spi_ee_cmd
    import spi_ee_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int PAGE_W    = 8,
    localparam int PAGE     = 1 << PAGE_W,
    localparam int PIDX_W   = ADDR_W - PAGE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  spi_ev_t              ev,
    input  logic                 wip,
    input  logic [7:0]           rd_data,
    output logic [ADDR_W-1:0]    rd_addr,
    output logic                 commit,
    output logic [PIDX_W-1:0]    commit_page,
    output logic [PAGE-1:0][7:0] pbuf,
    output logic [PAGE-1:0]      pmask,
    output logic                 so,
    output logic                 so_oe
);
    ee_phase_t         ph;
    ee_stat_t          sreg;
    logic [2:0]        bcnt;
    logic [6:0]        shin;
    logic [15:0]       addr_sh;
    logic [1:0]        acnt;
    logic              is_rd;
    logic [PAGE_W-1:0] wptr;
    logic              got_byte;
    logic [2:0]        sr_pend;
    logic [7:0]        obyte;
    logic [2:0]        obit;
    logic              load_q;
    logic              wip_q;
    logic [7:0]        new_byte;
    logic [23:0]       a_next;
    logic              byte_done;
    logic              wr_strobe;
    logic              unused_addr;

    assign new_byte    = {shin, ev.mosi};
    assign a_next      = {addr_sh, new_byte};
    assign byte_done   = ev.sck_rise && (bcnt == 3'd7);
    assign wr_strobe   = byte_done && (ph == PH_WDATA);
    assign unused_addr = ^a_next[23:ADDR_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ph          <= PH_IDLE;
            sreg        <= '0;
            bcnt        <= '0;
            shin        <= '0;
            addr_sh     <= '0;
            acnt        <= '0;
            is_rd       <= 1'b0;
            wptr        <= '0;
            got_byte    <= 1'b0;
            sr_pend     <= '0;
            obyte       <= '0;
            obit        <= '0;
            load_q      <= 1'b0;
            wip_q       <= 1'b0;
            so          <= 1'b0;
            so_oe       <= 1'b0;
            commit      <= 1'b0;
            commit_page <= '0;
            pmask       <= '0;
            rd_addr     <= '0;
        end else begin
            commit <= 1'b0;
            load_q <= 1'b0;
            wip_q  <= wip;
            if (wip_q && !wip) sreg.wel <= 1'b0;

            if (ev.sel_start) begin
                ph    <= PH_OPC;
                bcnt  <= '0;
                obit  <= '0;
                so_oe <= 1'b0;
            end else if (ev.sel_end) begin
                case (ph)
                    PH_ARMED: if (bcnt == 3'd0) sreg.wel <= 1'b1;
                    PH_WDATA: if (bcnt == 3'd0 && got_byte) commit <= 1'b1;
                    PH_SRDATA: if (bcnt == 3'd0 && got_byte) begin
                        commit    <= 1'b1;
                        sreg.wpen <= sr_pend[2];
                        sreg.bp   <= sr_pend[1:0];
                    end
                    default: ;
                endcase
                ph    <= PH_IDLE;
                so_oe <= 1'b0;
            end else if (ev.sck_rise && ph != PH_IDLE) begin
                bcnt <= bcnt + 1'b1;
                shin <= new_byte[6:0];
                if (ph == PH_ARMED) begin
                    ph <= PH_IGNORE;
                end else if (bcnt == 3'd7) begin
                    case (ph)
                        PH_OPC: begin
                            acnt <= '0;
                            case (new_byte)
                                OP_ARM:    ph <= wip ? PH_IGNORE : PH_ARMED;
                                OP_STATRD: begin
                                    ph     <= PH_RSTAT;
                                    load_q <= 1'b1;
                                end
                                OP_PROG: begin
                                    ph    <= (sreg.wel && !wip) ? PH_ADDR : PH_IGNORE;
                                    is_rd <= 1'b0;
                                end
                                OP_FETCH: begin
                                    ph    <= wip ? PH_IGNORE : PH_ADDR;
                                    is_rd <= 1'b1;
                                end
                                OP_STATWR: begin
                                    ph       <= (sreg.wel && !wip) ? PH_SRDATA : PH_IGNORE;
                                    got_byte <= 1'b0;
                                    if (sreg.wel && !wip) pmask <= '0;
                                end
                                default:   ph <= PH_IGNORE;
                            endcase
                        end
                        PH_ADDR: begin
                            addr_sh <= a_next[15:0];
                            acnt    <= acnt + 1'b1;
                            if (acnt == 2'd2) begin
                                if (is_rd) begin
                                    ph      <= PH_RDATA;
                                    rd_addr <= a_next[ADDR_W-1:0];
                                    load_q  <= 1'b1;
                                end else begin
                                    ph          <= PH_WDATA;
                                    wptr        <= a_next[PAGE_W-1:0];
                                    commit_page <= a_next[ADDR_W-1:PAGE_W];
                                    pmask       <= '0;
                                    got_byte    <= 1'b0;
                                end
                            end
                        end
                        PH_WDATA: begin
                            pmask[wptr] <= 1'b1;
                            wptr        <= wptr + 1'b1;
                            got_byte    <= 1'b1;
                        end
                        PH_SRDATA: begin
                            sr_pend  <= {new_byte[7], new_byte[3:2]};
                            got_byte <= 1'b1;
                        end
                        default: ;
                    endcase
                end
            end else if (ev.sck_fall && (ph == PH_RSTAT || ph == PH_RDATA)) begin
                so    <= obyte[3'd7 - obit];
                obit  <= obit + 1'b1;
                so_oe <= 1'b1;
                if (obit == 3'd7) load_q <= 1'b1;
            end

            if (load_q) begin
                obyte <= (ph == PH_RSTAT) ? stat_byte(sreg, wip) : rd_data;
                if (ph == PH_RDATA) rd_addr <= rd_addr + 1'b1;
            end
        end
    end

    // page buffer holds data only; no reset needed
    always_ff @(posedge clk) begin
        if (wr_strobe) pbuf[wptr] <= new_byte;
    end

    a_r2_latch_on_frame_end: assert property (@(posedge clk) disable iff (rst)
        $rose(sreg.wel) |-> $past(ev.sel_end));
    a_r7_commit_on_frame_end: assert property (@(posedge clk) disable iff (rst)
        commit |-> $past(ev.sel_end));
    a_r9_latch_clears: assert property (@(posedge clk) disable iff (rst)
        $fell(wip) |=> !sreg.wel);
    a_r10_no_drive_busy_fetch: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_IGNORE) |-> !so_oe);

endmodule

// File: rtl/spi_ee_slave.sv
module spi_ee_slave
    import spi_ee_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int PAGE_W      = 8,
    parameter int WR_CYCLES   = 300,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_clk,
    input  logic sel_n,
    input  logic ser_in,
    output logic ser_out,
    output logic ser_out_en
);
    localparam int PAGE   = 1 << PAGE_W;
    localparam int PIDX_W = ADDR_W - PAGE_W;

    spi_ev_t              ev;
    logic                 wip;
    logic [7:0]           rd_data;
    logic [ADDR_W-1:0]    rd_addr;
    logic                 commit;
    logic [PIDX_W-1:0]    commit_page;
    logic [PAGE-1:0][7:0] pbuf;
    logic [PAGE-1:0]      pmask;

    spi_ee_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .sck_in   (ser_clk),
        .sel_n_in (sel_n),
        .din_in   (ser_in),
        .ev       (ev)
    );

    spi_ee_cmd #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_cmd (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .wip         (wip),
        .rd_data     (rd_data),
        .rd_addr     (rd_addr),
        .commit      (commit),
        .commit_page (commit_page),
        .pbuf        (pbuf),
        .pmask       (pmask),
        .so          (ser_out),
        .so_oe       (ser_out_en)
    );

    spi_ee_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_array (
        .clk        (clk),
        .rst        (rst),
        .start      (commit),
        .start_page (commit_page),
        .pbuf       (pbuf),
        .pmask      (pmask),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .wip        (wip)
    );

    a_r13_quiet_when_deselected: assert property (@(posedge clk) disable iff (rst)
        !ev.selected |=> !ser_out_en);

endmodule

// File: tb/tb_spi_ee_slave.sv
module tb_spi_ee_slave;
    localparam int ADDR_W = 10;
    localparam int PAGE_W = 8;
    localparam int WRC    = 300;
    localparam int HALF   = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0;
    logic sel_n = 1'b1;
    logic ser_in = 1'b0;
    logic ser_out, ser_out_en;

    always #5 clk = ~clk;

    spi_ee_slave #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WRC)) dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .sel_n(sel_n), .ser_in(ser_in),
        .ser_out(ser_out), .ser_out_en(ser_out_en)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int hi_cnt = 0;
    bit any_drive;

    // reference model
    int   m_mem [1 << ADDR_W];
    bit   m_wel, m_wip;
    logic [7:0] m_sr;

    function automatic logic [7:0] m_status();
        return {m_sr[7], 3'b000, m_sr[3:2], m_wel, m_wip};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // R13 every clock: select high for a while means no drive
    always @(negedge clk) begin
        if (!rst) begin
            hi_cnt = sel_n ? hi_cnt + 1 : 0;
            if (hi_cnt > 4) chk("R13 output enable with select high", int'(ser_out_en), 0);
        end
    end

    task automatic cs_lo();
        @(negedge clk) sel_n = 1'b0;
        any_drive = 0;
        repeat (HALF) @(posedge clk);
    endtask

    task automatic cs_hi();
        repeat (HALF) @(posedge clk);
        @(negedge clk) sel_n = 1'b1;
        repeat (3 * HALF) @(posedge clk);
    endtask

    task automatic xbit(input logic b, output logic r);
        @(negedge clk) ser_in = b;
        repeat (HALF) @(posedge clk);
        @(negedge clk);
        r = ser_out_en ? ser_out : 1'b0;
        if (ser_out_en) any_drive = 1;
        ser_clk = 1'b1;
        repeat (HALF) @(posedge clk);
        @(negedge clk) ser_clk = 1'b0;
    endtask

    task automatic xbyte(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) xbit(b[i], r[i]);
    endtask

    task automatic t_wren();
        logic [7:0] r;
        cs_lo(); xbyte(8'h06, r); cs_hi();
        if (!m_wip) m_wel = 1;
    endtask

    task automatic t_rdsr(input string tag);
        logic [7:0] r;
        logic [7:0] e;
        cs_lo(); xbyte(8'h05, r);
        e = m_status();
        xbyte(8'h00, r); cs_hi();
        chk(tag, r, e);
    endtask

    task automatic t_write(input logic [23:0] a, input logic [7:0] d[$], input int extra, input bit pre_arm);
        logic [7:0] r;
        logic rb;
        int tmp [1 << ADDR_W];
        int off, pg;
        cs_lo();
        if (pre_arm) xbyte(8'h06, r);
        xbyte(8'h02, r);
        xbyte(a[23:16], r); xbyte(a[15:8], r); xbyte(a[7:0], r);
        foreach (d[i]) xbyte(d[i], r);
        for (int i = 0; i < extra; i++) xbit(1'b1, rb);
        cs_hi();
        if (!pre_arm && m_wel && !m_wip && extra == 0 && d.size() > 0) begin
            tmp = m_mem;
            pg  = int'(a[ADDR_W-1:PAGE_W]);
            off = int'(a[PAGE_W-1:0]);
            foreach (d[i]) begin
                tmp[(pg << PAGE_W) + off] = int'(d[i]);
                off = (off + 1) % (1 << PAGE_W);
            end
            m_mem = tmp;
            m_wip = 1;
        end
    endtask

    task automatic t_wrsr(input logic [7:0] v);
        logic [7:0] r;
        cs_lo(); xbyte(8'h01, r); xbyte(v, r); cs_hi();
        if (m_wel && !m_wip) begin
            m_sr  = v & 8'h8C;
            m_wip = 1;
        end
    endtask

    task automatic t_read(input logic [23:0] a, input int n, input string tag);
        logic [7:0] r;
        int idx;
        bit busy;
        busy = m_wip;
        cs_lo();
        xbyte(8'h03, r);
        xbyte(a[23:16], r); xbyte(a[15:8], r); xbyte(a[7:0], r);
        for (int i = 0; i < n; i++) begin
            xbyte(8'h00, r);
            idx = (int'(a[ADDR_W-1:0]) + i) % (1 << ADDR_W);
            if (!busy && m_mem[idx] >= 0) chk(tag, r, m_mem[idx]);
        end
        cs_hi();
        if (busy) chk({tag, " drive during busy"}, int'(any_drive), 0);
    endtask

    task automatic t_wait();
        repeat (WRC + 40) @(posedge clk);
        if (m_wip) begin
            m_wip = 0;
            m_wel = 0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic rb;
        foreach (m_mem[i]) m_mem[i] = -1;
        m_wel = 0; m_wip = 0; m_sr = 8'h00;
        repeat (5) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        repeat (5) @(posedge clk);

        // R1: reset state
        @(negedge clk) chk("R1 output enable after reset", int'(ser_out_en), 0);
        t_rdsr("R1 R3 status after reset");

        // R2: enable frame with a ninth bit does not arm
        cs_lo(); xbyte(8'h06, r); xbit(1'b0, rb); cs_hi();
        t_rdsr("R2 extra bit after enable");

        // R4: write without latch
        t_write(24'h000100, '{8'hAA}, 0, 0);
        t_rdsr("R4 status after unarmed write");

        // R2 R3: proper enable
        t_wren();
        t_rdsr("R2 R3 latch set by enable frame");

        // R5 R10: write, then refused read during busy
        t_write(24'hFE0100, '{8'h11, 8'h22, 8'h33}, 0, 0);
        t_read(24'h000100, 2, "R10 array read refused");
        t_wait();
        t_rdsr("R9 latch cleared after cycle");
        t_read(24'hAB0100, 3, "R5 read back with high address bits");

        // R4: unarmed write leaves data
        t_write(24'h000100, '{8'h99}, 0, 0);
        t_rdsr("R4 no busy after unarmed write");
        t_read(24'h000100, 1, "R4 array unchanged");

        // R8: busy seen right after commit
        t_wren();
        t_write(24'h0001FE, '{8'hA0, 8'hA1, 8'hA2, 8'hA3}, 0, 0);
        t_rdsr("R8 busy and latch during cycle");
        t_wait();
        t_rdsr("R8 R9 idle after cycle");
        t_read(24'h0001FE, 2, "R6 page tail");
        t_read(24'h000100, 3, "R6 R14 page head wrapped and untouched byte");

        // R11: enable and write during busy are ignored
        t_wren();
        t_write(24'h000300, '{8'h44}, 0, 0);
        t_wren();
        t_write(24'h000300, '{8'h77}, 0, 0);
        t_wait();
        t_rdsr("R11 enable during busy ignored");
        t_read(24'h000300, 1, "R11 write during busy ignored");

        // R7: abort on non-boundary select rise
        t_wren();
        t_write(24'h000100, '{8'h5A}, 3, 0);
        t_rdsr("R7 no cycle and latch kept after abort");
        t_read(24'h000100, 1, "R7 array unchanged after abort");
        t_write(24'h000101, '{}, 0, 0);
        t_rdsr("R7 no data bytes gives no cycle");
        t_write(24'h000200, '{8'h66}, 0, 0);
        t_wait();
        t_read(24'h000200, 1, "R5 R7 write after abort commits");

        // R2: write in same frame as enable
        t_write(24'h000200, '{8'h12}, 0, 1);
        t_rdsr("R2 same-frame enable leaves latch clear");
        t_read(24'h000200, 1, "R2 same-frame write not stored");

        // R12: status write
        t_wren();
        t_wrsr(8'h8C);
        t_rdsr("R12 R3 status bits with busy");
        t_wait();
        t_rdsr("R12 status bits stored");
        t_wren();
        t_wrsr(8'h7F);
        t_wait();
        t_rdsr("R12 only bits 7 3 2 stored");
        t_wrsr(8'h80);
        t_wait();
        t_rdsr("R12 status write needs latch");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule